// File: doc/BRIEF.md
# Serial Divider-Configuration Receiver

This block takes configuration words for a pair of frequency-synthesizer sections over a three-wire serial link: a data line, a serial clock and a load strobe. All three wires come in unrelated to the system clock, so each passes through a synchronizer chain. The block detects serial-clock rising edges and load-strobe rising edges in the system clock domain. Each serial-clock edge shifts one data bit into a 23-bit register. The first bit sent ends up at the most significant end.

On a load-strobe rising edge, the two bits at the least significant end of the register are an address. The address picks one of four holding registers: the reference-ratio register or the main-divider register of section A or section B. Reference words are 18 bits long, and any older bits above them are ignored. Main-divider words fill all 23 bits. A word that carries a divide ratio below the legal minimum is refused. The target register then keeps its contents and a sticky error flag is raised. The flag clears on the next accepted word.

The held fields leave the block as parallel outputs for the divider datapaths: reference ratios, main counts, swallow counts, prescaler select, comparator polarity, output-select and test bits, plus a one-hot monitor selection.

Top module: `synth_serial_cfg`

## Requirements
- R1: Each rising edge of the serial clock shifts the data bit into bit 0 of a 23-bit register. All older bits move up one place and bit 22 is dropped, so after any number of shifts the register holds the last 23 bits sent, the earliest of them at bit 22.
- R2: On a load, register bits [1:0] (bit 0 = last bit sent) select the target: 00 section A reference, 01 section B reference, 10 section A main divider, 11 section B main divider.
- R3: A reference word uses register bits [3:2] as test bits (bit 2 = T1, bit 3 = T2) and bits [17:4] as the 14-bit reference ratio, with bit 4 as its LSB. Register bits 22..18 have no effect on a reference load.
- R4: A main-divider word uses register bit 2 as output-select, bit 3 as prescaler select, bit 4 as comparator polarity, bits [11:5] as the 7-bit swallow count and bits [22:12] as the 11-bit main count.
- R5: Held registers change only on a rising edge of the load strobe. Serial clocking with the strobe low, or with the strobe held high after its edge, leaves every output unchanged.
- R6: A reference load with ratio below 5, or a main load with main count below 5, leaves the target register unchanged. A ratio of exactly 5 is accepted. A swallow count of 0 is accepted.
- R7: `cfg_err_o` goes to 1 on a refused load and stays at 1 until the next accepted load, which clears it.
- R8: `mon_sel_o` is one-hot. Its set bit index is {T2,T1} of the last accepted reference word, from either section: bit 0 = reference pulse of A, bit 1 = reference pulse of B, bit 2 = feedback pulse of A, bit 3 = feedback pulse of B.
- R9: After reset all held fields and `cfg_err_o` are 0 and `mon_sel_o` is 0001. The shift register is also zero, so a load with no bits shifted in is a refused section-A reference load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous |
| ref_ratio_o | output | 28 | Reference ratios, section A in [13:0], section B in [27:14] |
| test_bits_o | output | 4 | {T2,T1} per section, A in [1:0] |
| mon_sel_o | output | 4 | One-hot monitor selection |
| main_cnt_o | output | 22 | Main counts, A in [10:0] |
| swallow_o | output | 14 | Swallow counts, A in [6:0] |
| psel_o | output | 2 | Prescaler select per section, bit 0 = A |
| pol_o | output | 2 | Comparator polarity per section |
| lds_o | output | 2 | Output-select bit per section |
| cfg_err_o | output | 1 | Sticky refused-load flag |

## Verification
The bench targets ratios at the boundary (4 refused, 5 accepted, the 14-bit maximum), a swallow count of zero, and reference words preceded by stale upper bits. A design that decoded those stale bits, or compared with the wrong bound, would corrupt a ratio or refuse a legal one. It sends bursts longer than 23 bits, which catch a register that keeps the wrong end. It also clocks a whole new word while the strobe stays high, which catches a level-sensitive load that would overwrite the held fields early. Error-flag sequences check that a refused load leaves every output alone and that only an accepted load clears the flag. Random words over all four addresses catch crossed section or address decoding.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
   localparam int unsigned DEF_SR_W     = 23;
   localparam int unsigned DEF_REF_W    = 14;
   localparam int unsigned DEF_SWL_W    = 7;
   localparam int unsigned DEF_MAIN_W   = 11;
   localparam int unsigned DEF_MIN_DIV  = 5;
   localparam int unsigned DEF_SYNC     = 2;
   localparam int unsigned ADR_W        = 2;
   localparam int unsigned NSEC         = 2;
   localparam int unsigned MON_W        = 4;

   typedef enum logic [1:0] {
      DST_REF_A  = 2'b00,
      DST_REF_B  = 2'b01,
      DST_MAIN_A = 2'b10,
      DST_MAIN_B = 2'b11
   } cfg_dst_e;
endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          EDGE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_in_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   if (EDGE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= chain_q[STAGES-1];
      end
      assign q_o = chain_q[STAGES-1] & ~prev_q;
   end else begin : g_level
      assign q_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
   parameter int unsigned W = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb_i,
   input  logic         dat_i,
   output logic [W-1:0] sr_o
);
   if (W < 2) begin : g_bad_w
      $error("cfg_shifter width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr_o <= '0;
      else if (stb_i) sr_o <= {sr_o[W-2:0], dat_i};
   end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
   import synth_cfg_pkg::*;
#(
   parameter int unsigned SR_W    = DEF_SR_W,
   parameter int unsigned REF_W   = DEF_REF_W,
   parameter int unsigned SWL_W   = DEF_SWL_W,
   parameter int unsigned MAIN_W  = DEF_MAIN_W,
   parameter int unsigned MIN_DIV = DEF_MIN_DIV
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic [SR_W-1:0]           word_i,
   output logic [NSEC*REF_W-1:0]     ref_ratio_o,
   output logic [2*NSEC-1:0]         test_bits_o,
   output logic [MON_W-1:0]          mon_sel_o,
   output logic [NSEC*MAIN_W-1:0]    main_cnt_o,
   output logic [NSEC*SWL_W-1:0]     swallow_o,
   output logic [NSEC-1:0]           psel_o,
   output logic [NSEC-1:0]           pol_o,
   output logic [NSEC-1:0]           lds_o,
   output logic                      cfg_err_o
);
   localparam int unsigned TST_LSB  = ADR_W;
   localparam int unsigned REF_LSB  = ADR_W + 2;
   localparam int unsigned REF_LEN  = REF_LSB + REF_W;
   localparam int unsigned LDS_BIT  = ADR_W;
   localparam int unsigned PSEL_BIT = ADR_W + 1;
   localparam int unsigned POL_BIT  = ADR_W + 2;
   localparam int unsigned SWL_LSB  = ADR_W + 3;
   localparam int unsigned MAIN_LSB = SWL_LSB + SWL_W;

   if (MAIN_LSB + MAIN_W != SR_W) begin : g_bad_main_len
      $error("main-divider word must fill the shift register");
   end
   if (REF_LEN > SR_W) begin : g_bad_ref_len
      $error("reference word longer than the shift register");
   end
   if (MIN_DIV >= (1 << MAIN_W) || MIN_DIV >= (1 << REF_W)) begin : g_bad_min
      $error("minimum ratio not representable");
   end

   cfg_dst_e              dst;
   logic                  is_main;
   logic                  sec;
   logic [REF_W-1:0]      ref_fld;
   logic [1:0]            tst_fld;
   logic [MAIN_W-1:0]     main_fld;
   logic [SWL_W-1:0]      swl_fld;
   logic                  ref_ok;
   logic                  main_ok;
   logic [1:0]            mon_idx_q;
   logic                  err_q;

   assign dst      = cfg_dst_e'(word_i[ADR_W-1:0]);
   assign is_main  = (dst == DST_MAIN_A) || (dst == DST_MAIN_B);
   assign sec      = (dst == DST_REF_B)  || (dst == DST_MAIN_B);
   assign ref_fld  = word_i[REF_LSB +: REF_W];
   assign tst_fld  = word_i[TST_LSB +: 2];
   assign main_fld = word_i[MAIN_LSB +: MAIN_W];
   assign swl_fld  = word_i[SWL_LSB +: SWL_W];
   assign ref_ok   = ref_fld  >= REF_W'(MIN_DIV);
   assign main_ok  = main_fld >= MAIN_W'(MIN_DIV);

   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      logic [REF_W-1:0]  ref_q;
      logic [1:0]        tst_q;
      logic [MAIN_W-1:0] main_q;
      logic [SWL_W-1:0]  swl_q;
      logic              psel_q;
      logic              pol_q;
      logic              lds_q;
      logic              hit_ref;
      logic              hit_main;

      assign hit_ref  = load_i && !is_main && (sec == 1'(s)) && ref_ok;
      assign hit_main = load_i &&  is_main && (sec == 1'(s)) && main_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ref_q <= '0;
            tst_q <= '0;
         end else if (hit_ref) begin
            ref_q <= ref_fld;
            tst_q <= tst_fld;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            main_q <= '0;
            swl_q  <= '0;
            psel_q <= 1'b0;
            pol_q  <= 1'b0;
            lds_q  <= 1'b0;
         end else if (hit_main) begin
            main_q <= main_fld;
            swl_q  <= swl_fld;
            psel_q <= word_i[PSEL_BIT];
            pol_q  <= word_i[POL_BIT];
            lds_q  <= word_i[LDS_BIT];
         end
      end

      assign ref_ratio_o[s*REF_W +: REF_W]   = ref_q;
      assign test_bits_o[s*2 +: 2]           = tst_q;
      assign main_cnt_o[s*MAIN_W +: MAIN_W]  = main_q;
      assign swallow_o[s*SWL_W +: SWL_W]     = swl_q;
      assign psel_o[s]                       = psel_q;
      assign pol_o[s]                        = pol_q;
      assign lds_o[s]                        = lds_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q     <= 1'b0;
         mon_idx_q <= '0;
      end else if (load_i) begin
         if (is_main) begin
            err_q <= !main_ok;
         end else begin
            err_q <= !ref_ok;
            if (ref_ok) mon_idx_q <= tst_fld;
         end
      end
   end

   for (genvar m = 0; m < MON_W; m++) begin : g_mon
      assign mon_sel_o[m] = (mon_idx_q == 2'(m));
   end

   assign cfg_err_o = err_q;
endmodule

// File: rtl/synth_serial_cfg.sv
module synth_serial_cfg
   import synth_cfg_pkg::*;
#(
   parameter int unsigned SR_W    = DEF_SR_W,
   parameter int unsigned REF_W   = DEF_REF_W,
   parameter int unsigned SWL_W   = DEF_SWL_W,
   parameter int unsigned MAIN_W  = DEF_MAIN_W,
   parameter int unsigned MIN_DIV = DEF_MIN_DIV,
   parameter int unsigned SYNC    = DEF_SYNC
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ser_clk_i,
   input  logic                      ser_dat_i,
   input  logic                      ser_le_i,
   output logic [NSEC*REF_W-1:0]     ref_ratio_o,
   output logic [2*NSEC-1:0]         test_bits_o,
   output logic [MON_W-1:0]          mon_sel_o,
   output logic [NSEC*MAIN_W-1:0]    main_cnt_o,
   output logic [NSEC*SWL_W-1:0]     swallow_o,
   output logic [NSEC-1:0]           psel_o,
   output logic [NSEC-1:0]           pol_o,
   output logic [NSEC-1:0]           lds_o,
   output logic                      cfg_err_o
);
   logic            sclk_rise;
   logic            dat_s;
   logic            le_rise;
   logic [SR_W-1:0] sr_q;

   cfg_in_sync #(.STAGES(SYNC), .EDGE(1'b1)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .q_o(sclk_rise));

   cfg_in_sync #(.STAGES(SYNC), .EDGE(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d_i(ser_dat_i), .q_o(dat_s));

   cfg_in_sync #(.STAGES(SYNC), .EDGE(1'b1)) u_sync_le (
      .clk(clk), .rst_n(rst_n), .d_i(ser_le_i), .q_o(le_rise));

   cfg_shifter #(.W(SR_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .stb_i(sclk_rise), .dat_i(dat_s), .sr_o(sr_q));

   cfg_latch_bank #(
      .SR_W(SR_W), .REF_W(REF_W), .SWL_W(SWL_W),
      .MAIN_W(MAIN_W), .MIN_DIV(MIN_DIV)
   ) u_bank (
      .clk(clk),
      .rst_n(rst_n),
      .load_i(le_rise),
      .word_i(sr_q),
      .ref_ratio_o(ref_ratio_o),
      .test_bits_o(test_bits_o),
      .mon_sel_o(mon_sel_o),
      .main_cnt_o(main_cnt_o),
      .swallow_o(swallow_o),
      .psel_o(psel_o),
      .pol_o(pol_o),
      .lds_o(lds_o),
      .cfg_err_o(cfg_err_o)
   );
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
   import synth_cfg_pkg::*;
#(
   parameter int unsigned SR_W    = DEF_SR_W,
   parameter int unsigned REF_W   = DEF_REF_W,
   parameter int unsigned SWL_W   = DEF_SWL_W,
   parameter int unsigned MAIN_W  = DEF_MAIN_W,
   parameter int unsigned MIN_DIV = DEF_MIN_DIV
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sclk_rise,
   input logic                   dat_s,
   input logic                   le_rise,
   input logic [SR_W-1:0]        sr_q,
   input logic [NSEC*REF_W-1:0]  ref_ratio_o,
   input logic [2*NSEC-1:0]      test_bits_o,
   input logic [MON_W-1:0]       mon_sel_o,
   input logic [NSEC*MAIN_W-1:0] main_cnt_o,
   input logic [NSEC*SWL_W-1:0]  swallow_o,
   input logic [NSEC-1:0]        psel_o,
   input logic [NSEC-1:0]        pol_o,
   input logic [NSEC-1:0]        lds_o,
   input logic                   cfg_err_o
);
   // R1
   shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (sr_q == {$past(sr_q[SR_W-2:0]), $past(dat_s)}));

   // R1
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(sr_q));

   // R5
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable({ref_ratio_o, test_bits_o, main_cnt_o, swallow_o,
                            psel_o, pol_o, lds_o, mon_sel_o, cfg_err_o}));

   // R8
   mon_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mon_sel_o) == 1);

   // R7
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err_o) |-> $past(le_rise));

   // R7
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_err_o) |-> $past(le_rise));

   for (genvar s = 0; s < NSEC; s++) begin : g_floor
      // R6
      ref_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(ref_ratio_o[s*REF_W +: REF_W]) |->
            (ref_ratio_o[s*REF_W +: REF_W] >= REF_W'(MIN_DIV)));
      // R6
      main_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(main_cnt_o[s*MAIN_W +: MAIN_W]) |->
            (main_cnt_o[s*MAIN_W +: MAIN_W] >= MAIN_W'(MIN_DIV)));
   end
endmodule

bind synth_serial_cfg synth_cfg_chk #(
   .SR_W(SR_W), .REF_W(REF_W), .SWL_W(SWL_W),
   .MAIN_W(MAIN_W), .MIN_DIV(MIN_DIV)
) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .sclk_rise(sclk_rise),
   .dat_s(dat_s),
   .le_rise(le_rise),
   .sr_q(sr_q),
   .ref_ratio_o(ref_ratio_o),
   .test_bits_o(test_bits_o),
   .mon_sel_o(mon_sel_o),
   .main_cnt_o(main_cnt_o),
   .swallow_o(swallow_o),
   .psel_o(psel_o),
   .pol_o(pol_o),
   .lds_o(lds_o),
   .cfg_err_o(cfg_err_o)
);

// File: tb/sim_synth_serial_cfg.sv
module sim_synth_serial_cfg;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_le = 1'b0;
   logic [27:0] ref_ratio;
   logic [3:0]  test_bits;
   logic [3:0]  mon_sel;
   logic [21:0] main_cnt;
   logic [13:0] swallow;
   logic [1:0]  psel;
   logic [1:0]  pol;
   logic [1:0]  lds;
   logic        cfg_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [22:0] m_sr;
   logic [13:0] m_ref  [2];
   logic [1:0]  m_tst  [2];
   logic [10:0] m_n    [2];
   logic [6:0]  m_a    [2];
   logic        m_ps   [2];
   logic        m_pol  [2];
   logic        m_lds  [2];
   logic        m_err;
   logic [1:0]  m_mon;

   always #(CLK_NS/2) clk = ~clk;

   synth_serial_cfg u0 (
      .clk(clk), .rst_n(rst_n),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
      .ref_ratio_o(ref_ratio), .test_bits_o(test_bits), .mon_sel_o(mon_sel),
      .main_cnt_o(main_cnt), .swallow_o(swallow), .psel_o(psel),
      .pol_o(pol), .lds_o(lds), .cfg_err_o(cfg_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int s = 0; s < 2; s++) begin
         chk(req, $sformatf("ref[%0d]", s),  int'(ref_ratio[s*14 +: 14]), int'(m_ref[s]));
         chk(req, $sformatf("test[%0d]", s), int'(test_bits[s*2 +: 2]),  int'(m_tst[s]));
         chk(req, $sformatf("main[%0d]", s), int'(main_cnt[s*11 +: 11]), int'(m_n[s]));
         chk(req, $sformatf("swl[%0d]", s),  int'(swallow[s*7 +: 7]),    int'(m_a[s]));
         chk(req, $sformatf("psel[%0d]", s), int'(psel[s]), int'(m_ps[s]));
         chk(req, $sformatf("pol[%0d]", s),  int'(pol[s]),  int'(m_pol[s]));
         chk(req, $sformatf("lds[%0d]", s),  int'(lds[s]),  int'(m_lds[s]));
      end
      chk(req, "mon_sel", int'(mon_sel), int'(4'b0001 << m_mon));
      chk(req, "err", int'(cfg_err), int'(m_err));
   endtask

   // expected effect of a load, from R2, R3, R4, R6, R7, R8
   task automatic model_load();
      int s;
      s = int'(m_sr[0]);
      if (m_sr[1] == 1'b0) begin
         if (m_sr[17:4] >= 14'd5) begin
            m_ref[s] = m_sr[17:4];
            m_tst[s] = m_sr[3:2];
            m_mon    = m_sr[3:2];
            m_err    = 1'b0;
         end else m_err = 1'b1;
      end else begin
         if (m_sr[22:12] >= 11'd5) begin
            m_n[s]   = m_sr[22:12];
            m_a[s]   = m_sr[11:5];
            m_pol[s] = m_sr[4];
            m_ps[s]  = m_sr[3];
            m_lds[s] = m_sr[2];
            m_err    = 1'b0;
         end else m_err = 1'b1;
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) ser_dat = b;
      m_sr = {m_sr[21:0], b};
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_word(input logic [22:0] w, input int len);
      for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic le_up();
      @(negedge clk) ser_le = 1'b1;
      model_load();
      repeat (6) @(negedge clk);
   endtask

   task automatic le_down();
      @(negedge clk) ser_le = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_le();
      le_up();
      le_down();
   endtask

   function automatic logic [22:0] ref_word(input logic [13:0] r, input logic t1,
                                             input logic t2, input logic sec);
      return {5'b0, r, t2, t1, 1'b0, sec};
   endfunction

   function automatic logic [22:0] main_word(input logic [10:0] n, input logic [6:0] a,
                                              input logic fc, input logic sw,
                                              input logic ld, input logic sec);
      return {n, a, fc, sw, ld, 1'b1, sec};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired before completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      m_sr = '0; m_err = 1'b0; m_mon = 2'b00;
      for (int s = 0; s < 2; s++) begin
         m_ref[s] = '0; m_tst[s] = '0; m_n[s] = '0; m_a[s] = '0;
         m_ps[s] = 1'b0; m_pol[s] = 1'b0; m_lds[s] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R9: reset values
      check_all("R9");

      // R9: empty shift register -> refused section-A reference load
      pulse_le();
      check_all("R9");
      chk("R7", "err after empty load", int'(cfg_err), 1);

      // R3 and R2: section A reference, ratio 100
      send_word(ref_word(14'd100, 1'b0, 1'b0, 1'b0), 18);
      pulse_le();
      check_all("R3");

      // R6 boundary ratio 5 on section B, R8 test bits T1=1,T2=0
      send_word(ref_word(14'd5, 1'b1, 1'b0, 1'b1), 18);
      pulse_le();
      check_all("R6");
      chk("R8", "mon_sel refB", int'(mon_sel), 2);

      // R6 / R7: reference ratio 4 refused, flag set, latch kept
      send_word(ref_word(14'd4, 1'b1, 1'b1, 1'b0), 18);
      pulse_le();
      check_all("R7");
      chk("R6", "refA kept", int'(ref_ratio[13:0]), 100);

      // R6 / R7: main count 5 with swallow 0 accepted, flag cleared
      send_word(main_word(11'd5, 7'd0, 1'b1, 1'b0, 1'b1, 1'b0), 23);
      pulse_le();
      check_all("R6");
      chk("R7", "err cleared", int'(cfg_err), 0);

      // R4: extremes on section B main latch
      send_word(main_word(11'd2047, 7'd127, 1'b0, 1'b1, 1'b1, 1'b1), 23);
      pulse_le();
      check_all("R4");

      // R6: main count 4 refused
      send_word(main_word(11'd4, 7'd9, 1'b1, 1'b0, 1'b0, 1'b1), 23);
      pulse_le();
      check_all("R6");

      // R3: stale upper bits do not disturb a reference load, max ratio
      send_word({5'b11111, 18'(ref_word(14'd16383, 1'b0, 1'b1, 1'b1))}, 23);
      pulse_le();
      check_all("R3");
      chk("R8", "mon_sel fbA", int'(mon_sel), 4);

      // R1: burst of 30 bits, first 7 dropped
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      send_word(main_word(11'd777, 7'd33, 1'b1, 1'b1, 1'b0, 1'b0), 23);
      pulse_le();
      check_all("R1");

      // R5: full new word shifted while strobe stays high -> no change
      send_word(ref_word(14'd300, 1'b1, 1'b1, 1'b0), 18);
      le_up();
      check_all("R5");
      send_word(main_word(11'd1500, 7'd77, 1'b0, 1'b0, 1'b1, 1'b0), 23);
      check_all("R5");
      le_down();
      check_all("R5");
      pulse_le();
      check_all("R5");

      // R2 / R8: random words over all four destinations
      for (int it = 0; it < 56; it++) begin
         logic [1:0]  dst;
         logic [13:0] r;
         logic [10:0] n;
         int          len;
         dst = 2'($urandom_range(0, 3));
         if (dst[1] == 1'b0) begin
            r = (($urandom_range(0, 7)) == 0) ? 14'($urandom_range(0, 4))
                                               : 14'($urandom_range(5, 16383));
            len = ($urandom_range(0, 1) == 1) ? 23 : 18;
            send_word({5'($urandom), 18'(ref_word(r, 1'($urandom), 1'($urandom), dst[0]))}, len);
         end else begin
            n = (($urandom_range(0, 7)) == 0) ? 11'($urandom_range(0, 4))
                                               : 11'($urandom_range(5, 2047));
            send_word(main_word(n, 7'($urandom), 1'($urandom), 1'($urandom),
                                1'($urandom), dst[0]), 23);
         end
         pulse_le();
         check_all("R2");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule